// File: doc/BRIEF.md
# Boot-Mode Latch and Write-Once System Control Register

This block is one 8-bit system control register on a simple synchronous register bus. While reset is held, it samples two mode-select pins. When reset is released it keeps the last sample and derives from it one of four operating modes: single-chip, expanded, bootstrap and test. The register holds five fields:

- a boot-ROM enable bit;
- a special-mode bit;
- a mode bit;
- a bit that selects read visibility or clock gating;
- a 4-bit field that selects which maskable interrupt source is promoted.

Each field follows its own write rule. Some fields accept writes only in the special modes. One field accepts only the first write after reset. The special-mode bit can only be cleared.

The decoded outputs feed the neighbouring logic:

- the boot-ROM enable, which maps the 0xBF00 to 0xBFFF window;
- the external read-visibility enable;
- the clock-pin drive enable;
- the promoted-interrupt select;
- the current mode code.

The memory decoder and the interrupt priority resolver take these outputs but are outside the block.

Top module: `sysmode_ctl`

## Requirements
- R1: While `rst` is high the block samples `mode_b_pin` and `mode_a_pin`. After release, `cur_mode` = {special, mode} with these codes:
  - pins (b,a) = (1,0) gives code 0, single-chip;
  - pins (1,1) gives code 1, expanded;
  - pins (0,0) gives code 2, bootstrap;
  - pins (0,1) gives code 3, test.
- R2: The register sits at address 0x3C. Its bit layout is [7] boot-ROM enable, [6] special, [5] mode, [4] visibility, [3:0] promote select. `bus_rdata` returns all eight bits combinationally whenever `bus_addr` is 0x3C, and returns 0 for any other address. The select field resets to 4'b0101.
- R3: Reset sets the boot-ROM enable bit only in bootstrap mode. Reset sets the visibility bit only in test mode. In every other mode reset clears both.
- R4: A write changes the boot-ROM enable bit only while the special bit is 1.
- R5: A write changes the special bit only while the special bit is 1, and such a write can only clear it. Once the bit is 0 it stays 0 until reset.
- R6: While the special bit is 1, every write loads the mode bit. While the special bit is 0, a write loads the mode bit only if it is the first write to the register since reset. A first write in any mode counts as used.
- R7: Only the first write to the register since reset loads the visibility bit. This holds in every mode.
- R8: Three outputs follow the register bits:
  - `boot_rom_en` equals bit 7;
  - `rd_visible` = mode & visibility;
  - `clk_out_en` = mode | ~visibility, so with mode bit 0 a 1 in the visibility bit forces the clock pin low.
- R9: Every write loads the select field, and `prio_sel` outputs it.
- R10: Writes to any address other than 0x3C change nothing.
- R11: A write that legally changes the special bit or the mode bit is visible on `cur_mode` and on the decoded outputs in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; mode pins sampled while high |
| mode_b_pin | input | 1 | Mode-select pin B |
| mode_a_pin | input | 1 | Mode-select pin A |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| boot_rom_en | output | 1 | Boot-ROM window 0xBF00-0xBFFF mapped |
| rd_visible | output | 1 | Internal reads driven onto the external bus |
| clk_out_en | output | 1 | 1: clock pin driven, 0: clock pin held low |
| prio_sel | output | 4 | Promoted interrupt source select |
| cur_mode | output | 2 | Current mode code {special, mode} |

## Verification
The bench starts from each of the four pin combinations. It then applies a long pseudo-random write stream. The first few writes of the stream keep the special bit set, so special-mode privileges are exercised before the bit drops. Every fourth write goes to a neighbouring address, which tells a correct address decode from a sloppy one. A model in the bench applies the per-field rules and compares the whole register and every decoded output after each write. Starting from all four modes tells a once-only lock that depends on the mode apart from one that does not, and a clear-only special bit apart from a freely writable one.

// File: rtl/sysmode_pkg.sv
package sysmode_pkg;

  localparam int CTL_W  = 8;
  localparam int PSEL_W = 4;

  localparam int B_RBOOT = 7;
  localparam int B_SPEC  = 6;
  localparam int B_MODE  = 5;
  localparam int B_VIS   = 4;

  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'b00,
    MODE_EXPANDED = 2'b01,
    MODE_BOOT     = 2'b10,
    MODE_TEST     = 2'b11
  } op_mode_e;

  typedef struct packed {
    logic              rboot;
    logic              spec;
    logic              mode;
    logic              vis;
    logic [PSEL_W-1:0] psel;
  } ctl_word_t;

  function automatic op_mode_e pins_to_mode(input logic pin_b, input logic pin_a);
    return op_mode_e'({~pin_b, pin_a});
  endfunction

  function automatic ctl_word_t reset_word(input op_mode_e m, input logic [PSEL_W-1:0] psel_rst);
    ctl_word_t w;
    w.rboot = (m == MODE_BOOT);
    w.spec  = m[1];
    w.mode  = m[0];
    w.vis   = (m == MODE_TEST);
    w.psel  = psel_rst;
    return w;
  endfunction

endpackage

// File: rtl/sysmode_wr_guard.sv
module sysmode_wr_guard (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic spec_q,
  output logic rboot_we,
  output logic spec_we,
  output logic mode_we,
  output logic vis_we,
  output logic psel_we,
  output logic first_used
);

  logic used_q;

  always_ff @(posedge clk) begin
    if (rst)         used_q <= 1'b0;
    else if (wr_hit) used_q <= 1'b1;
  end

  assign first_used = used_q;
  assign rboot_we   = wr_hit & spec_q;
  assign spec_we    = wr_hit & spec_q;
  assign mode_we    = wr_hit & (spec_q | ~used_q);
  assign vis_we     = wr_hit & ~used_q;
  assign psel_we    = wr_hit;

  // R7
  vis_once_chk: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> !vis_we);

  // R6
  mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (first_used && !spec_q) |-> !mode_we);

endmodule

// File: rtl/sysmode_regs.sv
module sysmode_regs
  import sysmode_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ctl_word_t        rst_val,
  input  logic             rboot_we,
  input  logic             spec_we,
  input  logic             mode_we,
  input  logic             vis_we,
  input  logic             psel_we,
  input  logic [CTL_W-1:0] wdata,
  output ctl_word_t        q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= rst_val;
    end else begin
      if (rboot_we) q.rboot <= wdata[B_RBOOT];
      if (spec_we)  q.spec  <= q.spec & wdata[B_SPEC];
      if (mode_we)  q.mode  <= wdata[B_MODE];
      if (vis_we)   q.vis   <= wdata[B_VIS];
      if (psel_we)  q.psel  <= wdata[PSEL_W-1:0];
    end
  end

  // R5
  spec_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !q.spec |=> !q.spec);

  // R4
  rboot_locked_chk: assert property (@(posedge clk) disable iff (rst)
    !q.spec |=> $stable(q.rboot));

  // R9
  psel_load_chk: assert property (@(posedge clk) disable iff (rst)
    psel_we |=> q.psel == $past(wdata[PSEL_W-1:0]));

endmodule

// File: rtl/sysmode_outdec.sv
module sysmode_outdec
  import sysmode_pkg::*;
(
  input  ctl_word_t   q,
  output logic        boot_rom_en,
  output logic        rd_visible,
  output logic        clk_out_en,
  output logic [PSEL_W-1:0] prio_sel,
  output logic [1:0]  cur_mode
);

  op_mode_e mode_now;

  always_comb begin
    mode_now    = op_mode_e'({q.spec, q.mode});
    boot_rom_en = q.rboot;
    rd_visible  = q.mode & q.vis;
    clk_out_en  = q.mode | ~q.vis;
    prio_sel    = q.psel;
    cur_mode    = mode_now;
  end

  // R8
  always_comb begin
    vis_excl_chk: assert (!(rd_visible && !clk_out_en));
  end

endmodule

// File: rtl/sysmode_ctl.sv
module sysmode_ctl
  import sysmode_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h3C,
  parameter logic [3:0]      PSEL_RST = 4'b0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_b_pin,
  input  logic              mode_a_pin,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CTL_W-1:0]  bus_wdata,
  output logic [CTL_W-1:0]  bus_rdata,
  output logic              boot_rom_en,
  output logic              rd_visible,
  output logic              clk_out_en,
  output logic [PSEL_W-1:0] prio_sel,
  output logic [1:0]        cur_mode
);

  logic      addr_hit, wr_hit;
  logic      rboot_we, spec_we, mode_we, vis_we, psel_we, first_used;
  ctl_word_t rst_val, q;

  assign addr_hit  = (bus_addr == REG_ADDR);
  assign wr_hit    = bus_wr & addr_hit;
  assign rst_val   = reset_word(pins_to_mode(mode_b_pin, mode_a_pin), PSEL_RST);
  assign bus_rdata = addr_hit ? q : '0;

  sysmode_wr_guard u_guard (
    .clk        (clk),
    .rst        (rst),
    .wr_hit     (wr_hit),
    .spec_q     (q.spec),
    .rboot_we   (rboot_we),
    .spec_we    (spec_we),
    .mode_we    (mode_we),
    .vis_we     (vis_we),
    .psel_we    (psel_we),
    .first_used (first_used)
  );

  sysmode_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .rst_val  (rst_val),
    .rboot_we (rboot_we),
    .spec_we  (spec_we),
    .mode_we  (mode_we),
    .vis_we   (vis_we),
    .psel_we  (psel_we),
    .wdata    (bus_wdata),
    .q        (q)
  );

  sysmode_outdec u_dec (
    .q           (q),
    .boot_rom_en (boot_rom_en),
    .rd_visible  (rd_visible),
    .clk_out_en  (clk_out_en),
    .prio_sel    (prio_sel),
    .cur_mode    (cur_mode)
  );

  // R10
  foreign_addr_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(bus_rdata) || !$stable(bus_addr));

  // R11
  mode_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && $past(!rst) && q.spec) |=> cur_mode[0] == $past(bus_wdata[B_MODE]));

  // R7
  vis_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    first_used |=> $stable(q.vis));

endmodule

// File: tb/sysmode_ctl_tb.sv
module sysmode_ctl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pb = 1'b1, pa = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       brom, rvis, ckout;
  logic [3:0] psel;
  logic [1:0] cmode;

  int checks = 0;
  int fails  = 0;

  logic       m_rb, m_sp, m_md, m_vs, m_used;
  logic [3:0] m_ps;

  always #5 clk = ~clk;

  sysmode_ctl u_dut (
    .clk(clk), .rst(rst), .mode_b_pin(pb), .mode_a_pin(pa),
    .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata),
    .boot_rom_en(brom), .rd_visible(rvis), .clk_out_en(ckout),
    .prio_sel(psel), .cur_mode(cmode)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_word();
    return {m_rb, m_sp, m_md, m_vs, m_ps};
  endfunction

  task automatic check_all(input string ctx);
    addr = 8'h3C;
    #1;
    chk({ctx, " R2/R4/R5/R6/R7/R9 word"}, rdata, model_word());
    chk({ctx, " R8 boot_rom_en"}, {7'd0, brom}, {7'd0, m_rb});
    chk({ctx, " R8 rd_visible"}, {7'd0, rvis}, {7'd0, m_md && m_vs});
    chk({ctx, " R8 clk_out_en"}, {7'd0, ckout}, {7'd0, m_md || !m_vs});
    chk({ctx, " R9 prio_sel"}, {4'd0, psel}, {4'd0, m_ps});
    chk({ctx, " R11 cur_mode"}, {6'd0, cmode}, {6'd0, m_sp, m_md});
  endtask

  task automatic do_reset(input logic b, input logic a);
    @(negedge clk);
    rst = 1'b1; pb = b; pa = a; wr = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_sp = !b; m_md = a;
    m_rb = (!b && !a);
    m_vs = (!b && a);
    m_ps = 4'b0101;
    m_used = 1'b0;
    check_all("reset R1/R3");
    chk("R1 mode code", {6'd0, cmode}, {6'd0, !b, a});
    chk("R2 psel reset", {4'd0, psel}, 8'h05);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    logic hit;
    @(negedge clk);
    addr = a; wr = 1'b1; wdata = d;
    #1;
    if (a != 8'h3C) chk("R2 foreign read", rdata, 8'h00);
    hit = (a == 8'h3C);
    @(negedge clk);
    wr = 1'b0;
    if (hit) begin
      logic n_rb, n_sp, n_md, n_vs;
      n_rb = m_sp ? d[7] : m_rb;
      n_sp = m_sp ? d[6] : 1'b0;
      n_md = (m_sp || !m_used) ? d[5] : m_md;
      n_vs = m_used ? m_vs : d[4];
      m_rb = n_rb; m_sp = n_sp; m_md = n_md; m_vs = n_vs;
      m_ps = d[3:0];
      m_used = 1'b1;
    end
    check_all(hit ? "write" : "R10 foreign write");
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    for (int mi = 0; mi < 4; mi++) begin
      for (int rep = 0; rep < 3; rep++) begin
        do_reset(mi[1], mi[0]);
        for (int k = 0; k < 40; k++) begin
          logic [7:0] d;
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          d = lfsr;
          if (k < 4 + rep * 3) d[6] = 1'b1;
          do_write((k % 4 == 3) ? 8'h3D ^ {4'd0, k[3:0]} : 8'h3C, d);
        end
      end
    end
    // Directed: normal single-chip, first write sets mode bit, second is ignored (R6, R7)
    do_reset(1'b1, 1'b0);
    do_write(8'h3C, 8'hF3);
    chk("R6 first write mode", {6'd0, cmode}, 8'h01);
    chk("R7 first write vis", {7'd0, rdata[4]}, 8'h01);
    do_write(8'h3C, 8'h0A);
    chk("R6 second write ignored", {6'd0, cmode}, 8'h01);
    chk("R7 second write ignored", {7'd0, rdata[4]}, 8'h01);
    chk("R4 rboot blocked", {7'd0, brom}, 8'h00);
    // Directed: bootstrap, clear special then try to set it back (R5)
    do_reset(1'b0, 1'b0);
    do_write(8'h3C, 8'h00);
    do_write(8'h3C, 8'hC0);
    chk("R5 special stays clear", {7'd0, rdata[6]}, 8'h00);
    chk("R4 rboot stays clear", {7'd0, brom}, 8'h00);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule